// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block counts the movements of an incremental encoder that has two outputs, A and B. Both inputs are asynchronous to the system clock, so each passes through a synchroniser before it is decoded. A mode field selects how the inputs are used:

- **Single-channel on A:** A is the count input and B gives the direction.
- **Single-channel on B:** B is the count input and A gives the direction.
- **Quadrature:** both inputs are decoded together, giving four counts per encoder period with the direction taken from which input leads.

The counter runs between zero and a programmable limit. It wraps at either end. Each wrap raises a one-cycle update event.

Software controls the block through a small word-wide register port. Writes take effect on the clock edge. Read data appears one cycle after the address. Software can:

- enable and disable counting;
- choose the mode;
- read and overwrite the live count;
- program the limit, either directly or buffered until the next update event;
- read the direction of the most recent counted step.

Top module: `qenc_counter`

## Requirements
- R1: After synchronous reset the control word reads 0, the mode reads 0, the count reads 0 and the limit reads all ones of the count width.
- R2: With mode value 1, each rising edge of A moves the count by one: up when B is low, down when B is high. A falling edge of A and any edge of B do not move the count.
- R3: With mode value 2, each rising edge of B moves the count by one: up when A is low, down when A is high.
- R4: With mode value 3, every valid Gray-code transition of (A,B) moves the count by one. The order 00,10,11,01 (A written first) counts up and the reverse order counts down, so one full encoder period moves the count by four.
- R5: In mode 3, a sample in which both A and B changed together leaves the count unchanged.
- R6: The count does not move while the enable bit (control bit 0) is clear, nor while the mode holds 0 or any value from 4 to 7.
- R7: Counting up from a value equal to or above the active limit gives 0. Counting down from 0 gives the limit. Each such wrap drives `update_evt` high for exactly one cycle.
- R8: When the buffered-limit bit (control bit 7) is set, a written limit reads back at once but is used only from the next wrap. When that bit is clear, a written limit is used at once.
- R9: Direction bit 4 of the control word, and the `dir_out` port, show 0 after an up step and 1 after a down step.
- R10: The count register can be written, and a read returns the written value. Register offsets are: control 0x00, mode 0x08 (bits 2:0), count 0x24, limit 0x2C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| update_evt | output | 1 | One-cycle pulse on a wrap |
| dir_out | output | 1 | Direction of the last counted step, 1 for down |

## Verification
An input edge reaches the count register three clock edges after the pin changes. A missed or extra step therefore shows up on the next register read as a count that is off by one or more.

The following faults show at the ports within one encoder step:

- A wrongly latched direction, or a decoder that accepts a simultaneous change on A and B, makes the count drift the wrong way. It also leaves bit 4 of the control word wrong.
- A limit that is made active too early makes the wrap, and its `update_evt` pulse, fall on the wrong count value.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_ACNT = 3'd1,
    MODE_BCNT = 3'd2,
    MODE_QUAD = 3'd3
  } qmode_e;

  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_MODE  = 'h08;
  localparam int OFS_COUNT = 'h24;
  localparam int OFS_LIMIT = 'h2C;

  localparam int BIT_EN   = 0;
  localparam int BIT_DIR  = 4;
  localparam int BIT_BUFL = 7;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab,     // bit0 = A, bit1 = B, already synchronised
  input  logic [2:0] mode,
  output logic       step,
  output logic       down
);
  logic [1:0] prev;
  logic [1:0] pos_new, pos_old, delta;
  logic       a_rise, b_rise;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= ab;
  end

  assign a_rise  = ab[0] & ~prev[0];
  assign b_rise  = ab[1] & ~prev[1];
  // Gray (A,B) to position: 00->0, A only->1, both->2, B only->3
  assign pos_new = {ab[1], ab[0] ^ ab[1]};
  assign pos_old = {prev[1], prev[0] ^ prev[1]};
  assign delta   = pos_new - pos_old;

  always_comb begin
    step = 1'b0;
    down = 1'b0;
    case (mode)
      MODE_ACNT: begin step = a_rise; down = ab[1]; end
      MODE_BCNT: begin step = b_rise; down = ab[0]; end
      MODE_QUAD: begin
        step = (delta == 2'd1) || (delta == 2'd3);
        down = (delta == 2'd3);
      end
      default: ;
    endcase
  end

  AST_QUAD_NO_DOUBLE: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUAD && ab[0] != prev[0] && ab[1] != prev[1]) |-> !step); // R5
  AST_QUAD_A_LEADS_UP: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_QUAD && prev == 2'b00 && ab == 2'b01) |-> (step && !down)); // R4
  AST_IDLE_MODE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF || mode[2]) |-> !step); // R6
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic             down,
  input  logic             buf_lim,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             lim_wr,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic             dir_wr,
  input  logic             dir_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim_shadow,
  output logic             dir,
  output logic             evt
);
  logic [CNT_W-1:0] lim_act;
  logic             move, wrap_up, wrap_dn;

  assign move    = en && step && !cnt_wr;
  assign wrap_up = move && !down && (cnt >= lim_act);
  assign wrap_dn = move && down && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      evt <= 1'b0;
    end else begin
      evt <= wrap_up || wrap_dn;
      if (cnt_wr)       cnt <= cnt_wdata;
      else if (wrap_up) cnt <= '0;
      else if (wrap_dn) cnt <= lim_shadow;
      else if (move)    cnt <= down ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_shadow <= '1;
      lim_act    <= '1;
    end else begin
      if (lim_wr) lim_shadow <= lim_wdata;
      if (lim_wr && !buf_lim)       lim_act <= lim_wdata;
      else if (wrap_up || wrap_dn)  lim_act <= lim_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         dir <= 1'b0;
    else if (dir_wr) dir <= dir_wdata;
    else if (move)   dir <= down;
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(cnt)); // R6
  AST_EVT_ONE_CYCLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    evt |-> $past(en && step)); // R7
  AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (move && !down && cnt >= lim_act) |=> (cnt == '0 && evt)); // R7
  AST_DOWN_WRAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (move && down && cnt == '0) |=> (cnt == $past(lim_shadow) && evt)); // R7
  AST_BUFFERED_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (buf_lim && !move) |=> $stable(lim_act)); // R8
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              update_evt,
  output logic              dir_out
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [1:0]       ab_sync;
  logic [2:0]       mode_q;
  logic             en_q, buf_q;
  logic             step, down;
  logic [CNT_W-1:0] cnt, lim_shadow;
  logic             dir, evt;
  logic             wr_ctrl, wr_mode, wr_cnt, wr_lim;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_mode = reg_wr && (reg_addr == ADDR_W'(OFS_MODE));
  assign wr_cnt  = reg_wr && (reg_addr == ADDR_W'(OFS_COUNT));
  assign wr_lim  = reg_wr && (reg_addr == ADDR_W'(OFS_LIMIT));

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst(rst), .d({enc_b, enc_a}), .q(ab_sync)
  );

  qenc_decode u_dec (
    .clk(clk), .rst(rst), .ab(ab_sync), .mode(mode_q), .step(step), .down(down)
  );

  qenc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .step(step), .down(down), .buf_lim(buf_q),
    .cnt_wr(wr_cnt), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .lim_wr(wr_lim), .lim_wdata(reg_wdata[CNT_W-1:0]),
    .dir_wr(wr_ctrl), .dir_wdata(reg_wdata[BIT_DIR]),
    .cnt(cnt), .lim_shadow(lim_shadow), .dir(dir), .evt(evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      buf_q  <= 1'b0;
      mode_q <= MODE_OFF;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[BIT_EN];
        buf_q <= reg_wdata[BIT_BUFL];
      end
      if (wr_mode) mode_q <= reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      case (reg_addr)
        ADDR_W'(OFS_CTRL): begin
          reg_rdata[BIT_EN]   <= en_q;
          reg_rdata[BIT_DIR]  <= dir;
          reg_rdata[BIT_BUFL] <= buf_q;
        end
        ADDR_W'(OFS_MODE):  reg_rdata[2:0] <= mode_q;
        ADDR_W'(OFS_COUNT): reg_rdata <= {{PAD_W{1'b0}}, cnt};
        ADDR_W'(OFS_LIMIT): reg_rdata <= {{PAD_W{1'b0}}, lim_shadow};
        default: ;
      endcase
    end
  end

  assign update_evt = evt;
  assign dir_out    = dir;

  AST_EVT_SINGLE_PULSE_SLOW: assert property (@(posedge clk) disable iff (rst)
    (update_evt && mode_q != MODE_QUAD) |=> !update_evt); // R7
  AST_DIR_PORT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (en_q && step && !reg_wr) |=> (dir_out == $past(down))); // R9
endmodule

// File: tb/tb_qenc_counter.sv
module tb_qenc_counter;
  logic        clk = 0;
  logic        rst = 1;
  logic        enc_a = 0, enc_b = 0;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        update_evt, dir_out;

  int n_chk = 0, n_bad = 0, evt_seen = 0;
  bit done = 0;

  qenc_counter dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .update_evt(update_evt), .dir_out(dir_out)
  );

  always #5 clk = ~clk;

  always @(negedge clk) if (!rst && update_evt) evt_seen++;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    settle();
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin set_ab(1, enc_b); set_ab(0, enc_b); end
  endtask

  task automatic pulse_b(input int n);
    for (int i = 0; i < n; i++) begin set_ab(enc_a, 1); set_ab(enc_a, 0); end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd('h00, d); check("R1 ctrl", d, 0);
    rd('h08, d); check("R1 mode", d, 0);
    rd('h24, d); check("R1 count", d, 0);
    rd('h2C, d); check("R1 limit", d, 32'hFFFF);
    check("R1 evt", update_evt, 0);
  endtask

  task automatic t_mode_a();
    logic [31:0] d;
    wr('h00, 1); wr('h08, 1); wr('h24, 10);
    set_ab(0, 0);
    pulse_a(3);
    rd('h24, d); check("R2 up on A", d, 13);
    rd('h00, d); check("R9 dir up", d[4], 0);
    pulse_b(2);
    rd('h24, d); check("R2 B edges ignored", d, 13);
    set_ab(0, 1);
    pulse_a(2);
    rd('h24, d); check("R2 down on A", d, 11);
    rd('h00, d); check("R9 dir down", d[4], 1);
    check("R9 dir_out", dir_out, 1);
    set_ab(0, 0);
  endtask

  task automatic t_mode_b();
    logic [31:0] d;
    wr('h08, 2); wr('h24, 20);
    pulse_b(4);
    rd('h24, d); check("R3 up on B", d, 24);
    set_ab(1, 0);
    pulse_b(1);
    rd('h24, d); check("R3 down on B", d, 23);
    set_ab(0, 0);
  endtask

  task automatic t_quad();
    logic [31:0] d;
    wr('h08, 3); wr('h24, 100);
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    rd('h24, d); check("R4 quad up period", d, 104);
    check("R9 quad dir up", dir_out, 0);
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    set_ab(0, 1); set_ab(1, 1);
    rd('h24, d); check("R4 quad down", d, 98);
    check("R9 quad dir down", dir_out, 1);
    set_ab(0, 0);
    rd('h24, d); check("R5 both changed ignored", d, 98);
    set_ab(0, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wr('h08, 1); wr('h24, 7); wr('h00, 0);
    pulse_a(2);
    rd('h24, d); check("R6 disabled hold", d, 7);
    wr('h00, 1); wr('h08, 0);
    pulse_a(2);
    rd('h24, d); check("R6 mode 0 hold", d, 7);
    wr('h08, 5);
    pulse_a(1);
    rd('h24, d); check("R6 mode 5 hold", d, 7);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    int e0;
    wr('h00, 1); wr('h08, 1); wr('h2C, 5); wr('h24, 4);
    set_ab(0, 0);
    e0 = evt_seen;
    pulse_a(1);
    rd('h24, d); check("R7 reach limit", d, 5);
    check("R7 no early evt", evt_seen - e0, 0);
    pulse_a(1);
    rd('h24, d); check("R7 up wrap", d, 0);
    check("R7 one evt pulse up", evt_seen - e0, 1);
    wr('h24, 1);
    set_ab(0, 1);
    pulse_a(2);
    rd('h24, d); check("R7 down wrap", d, 5);
    check("R7 one evt pulse down", evt_seen - e0, 2);
    set_ab(0, 0);
  endtask

  task automatic t_preload();
    logic [31:0] d;
    wr('h00, 32'h81); wr('h24, 3); wr('h2C, 9);
    rd('h2C, d); check("R8 shadow readback", d, 9);
    pulse_a(2);
    rd('h24, d); check("R8 old limit still used", d, 5);
    pulse_a(1);
    rd('h24, d); check("R8 wrap at old limit", d, 0);
    pulse_a(6);
    rd('h24, d); check("R8 new limit active", d, 6);
    pulse_a(4);
    rd('h24, d); check("R8 wrap at new limit", d, 0);
    wr('h24, 32'h1234);
    rd('h24, d); check("R10 count write readback", d, 32'h1234);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_mode_a();
    t_mode_b();
    t_quad();
    t_disable();
    t_wrap();
    t_preload();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule